// File: doc/BRIEF.md
# Legacy System Control I/O Ports

This block sits on an 8-bit I/O bus and answers three fixed byte-wide port addresses found in a classic PC chipset. The first is the system control port. It holds one byte. Bit 1 of that byte requests the A20 address gate, and writing bit 0 as one asks the chip for a system reset. The second is a diagnostic sink: writes to it are dropped and reads return all ones. The third is a coprocessor-error acknowledge port. Writing any value to it lowers a latched floating-point error interrupt, and reads return all ones.

The A20 gate output combines the control-port request with a second request from the keyboard controller. The block has two resets. The power-on reset (`rst_n`) clears all of its state. The device reset (`dev_rst`) is synchronous and clears only the reset-request bit of the control byte. Bus responses are registered: read data and the acknowledge appear in the cycle after the strobe.

Top module: `legacy_sysctl_ports`

## Requirements
- R1: A byte write to address 0x0092 stores all eight data bits in the control byte. A later byte read of 0x0092 returns that byte unchanged.
- R2: `a20_gate` is high exactly when bit 1 of the control byte is one or `kbc_a20` is high.
- R3: A byte write to 0x0092 with data bit 0 set makes `sys_reset_req` high for exactly the one cycle after the write cycle. No other write produces the pulse.
- R4: Power-on reset clears the whole control byte. A `dev_rst` cycle clears bit 0 and keeps bits 7..1. In that cycle a control-port write is discarded and no reset pulse is issued.
- R5: Writes to 0x0080 change no state. Byte reads of 0x0080 return 0xFF.
- R6: A one-cycle `fpu_err` pulse sets `ferr_irq`, which then stays high. A byte write of any data to 0x00F0 lowers it one cycle later. Byte reads of 0x00F0 return 0xFF.
- R7: When `fpu_err` and a write to 0x00F0 occur in the same cycle, `ferr_irq` is high afterwards.
- R8: An access to any other address, including addresses that differ from a decoded port only in the upper bits, returns 0x00, raises no `io_ack` and changes no state.
- R9: An access with `io_wide` high is not a byte access. It is ignored like an undecoded access: no acknowledge, read data 0x00, no state change.
- R10: For a byte read or write to a decoded port, `io_ack` is high for one cycle, in the cycle after the strobe. Read data is valid in that same cycle, and `io_rdata` is 0x00 in every cycle that carries no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst | input | 1 | Synchronous device reset, clears only the reset-request bit |
| io_addr | input | ADDR_W | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wide | input | 1 | High for an access wider than one byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_ack | output | 1 | Registered access acknowledge |
| fpu_err | input | 1 | Floating-point error event pulse |
| kbc_a20 | input | 1 | A20 request from the keyboard controller |
| a20_gate | output | 1 | Combined A20 gate |
| sys_reset_req | output | 1 | One-cycle system reset request |
| ferr_irq | output | 1 | Latched floating-point error interrupt |

## Verification
Some behaviours are checked by assertions on every cycle:
- every reset pulse has a qualifying write one cycle earlier;
- a device reset preserves bits 7..1;
- an error event always leaves the interrupt high;
- the interrupt only falls after a clear write;
- the keyboard request always opens the gate;
- every acknowledge has a decoded byte access behind it.

The bench's scenarios are needed for the rest:
- the stored byte read back after other traffic;
- the all-ones sink values;
- addresses that alias in the low bits only;
- wide accesses that leave the state untouched.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RST_BIT = 0;
  localparam int unsigned A20_BIT = 1;

  // value returned by the write-sink ports
  function automatic logic [BYTE_W-1:0] sink_byte();
    return {BYTE_W{1'b1}};
  endfunction

  // next control byte: device reset drops only the reset-request bit
  function automatic logic [BYTE_W-1:0] ctrl_next(
      input logic [BYTE_W-1:0] cur,
      input logic              wr,
      input logic [BYTE_W-1:0] wdata,
      input logic              dev_rst);
    logic [BYTE_W-1:0] n;
    n = cur;
    if (dev_rst) n[RST_BIT] = 1'b0;
    else if (wr) n = wdata;
    return n;
  endfunction
endpackage

// File: rtl/io_port_decode.sv
module io_port_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 'h92,
  parameter logic [ADDR_W-1:0] POST_ADDR = 'h80,
  parameter logic [ADDR_W-1:0] FCLR_ADDR = 'hF0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              wide,
  output logic              wr_ctl,
  output logic              wr_fclr,
  output logic              rd_ctl,
  output logic              rd_sink,
  output logic              acc_hit
);
  localparam int unsigned NPORT = 3;
  localparam int unsigned IDX_CTL  = 0;
  localparam int unsigned IDX_POST = 1;
  localparam int unsigned IDX_FCLR = 2;
  localparam logic [NPORT*ADDR_W-1:0] PORT_TABLE = {FCLR_ADDR, POST_ADDR, CTL_ADDR};

  logic [NPORT-1:0] match;
  logic             byte_ok;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_match
      assign match[g] = (addr == PORT_TABLE[g*ADDR_W +: ADDR_W]);
    end
  endgenerate

  assign byte_ok = !wide;
  assign wr_ctl  = wr & byte_ok & match[IDX_CTL];
  assign wr_fclr = wr & byte_ok & match[IDX_FCLR];
  assign rd_ctl  = rd & byte_ok & match[IDX_CTL];
  assign rd_sink = rd & byte_ok & (match[IDX_POST] | match[IDX_FCLR]);
  assign acc_hit = (rd | wr) & byte_ok & (|match);
endmodule

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              reset_pulse
);
  logic fire_reset;
  assign fire_reset = wr_en & wdata[RST_BIT] & !dev_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      reset_pulse <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_next(ctrl_q, wr_en, wdata, dev_rst);
      reset_pulse <= fire_reset;
    end
  end

  // R3: every pulse traces back to a qualifying write one cycle earlier
  a_r3_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> $past(wr_en && wdata[RST_BIT] && !dev_rst));

  // R4: device reset keeps the upper bits and clears bit 0
  a_r4_devrst_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> (ctrl_q[BYTE_W-1:1] == $past(ctrl_q[BYTE_W-1:1])) && !ctrl_q[RST_BIT]);

  // R4: no reset pulse follows a device-reset cycle
  a_r4_devrst_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> !reset_pulse);
endmodule

// File: rtl/ferr_latch.sv
module ferr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  output logic ferr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ferr_q <= 1'b0;
    else if (set_evt) ferr_q <= 1'b1;
    else if (clr_wr)  ferr_q <= 1'b0;
  end

  // R7: an event always leaves the line high, even against a clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ferr_q);

  // R6: the line only falls after a clear write
  a_r6_held_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_q && !clr_wr) |=> ferr_q);
endmodule

// File: rtl/legacy_sysctl_ports.sv
module legacy_sysctl_ports
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 'h92,
  parameter logic [ADDR_W-1:0] POST_ADDR = 'h80,
  parameter logic [ADDR_W-1:0] FCLR_ADDR = 'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_wide,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_ack,
  input  logic              fpu_err,
  input  logic              kbc_a20,
  output logic              a20_gate,
  output logic              sys_reset_req,
  output logic              ferr_irq
);
  logic wr_ctl, wr_fclr, rd_ctl, rd_sink, acc_hit;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] rdata_d;

  io_port_decode #(
    .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .POST_ADDR(POST_ADDR), .FCLR_ADDR(FCLR_ADDR)
  ) i_dec (
    .addr(io_addr), .rd(io_rd), .wr(io_wr), .wide(io_wide),
    .wr_ctl(wr_ctl), .wr_fclr(wr_fclr), .rd_ctl(rd_ctl),
    .rd_sink(rd_sink), .acc_hit(acc_hit)
  );

  sysctl_ctrl_reg i_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .wr_en(wr_ctl),
    .wdata(io_wdata), .ctrl_q(ctrl_q), .reset_pulse(sys_reset_req)
  );

  ferr_latch i_ferr (
    .clk(clk), .rst_n(rst_n), .set_evt(fpu_err), .clr_wr(wr_fclr), .ferr_q(ferr_irq)
  );

  assign a20_gate = ctrl_q[A20_BIT] | kbc_a20;

  always_comb begin
    rdata_d = '0;
    if (rd_ctl)       rdata_d = ctrl_q;
    else if (rd_sink) rdata_d = sink_byte();
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_ack   <= 1'b0;
      io_rdata <= '0;
    end else begin
      io_ack   <= acc_hit;
      io_rdata <= rdata_d;
    end
  end

  // R2: keyboard request always opens the gate
  a_r2_kbc_opens_gate: assert property (@(posedge clk) disable iff (!rst_n)
    kbc_a20 |-> a20_gate);

  // R8: an acknowledge needs a decoded access one cycle before
  a_r8_ack_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |-> $past(acc_hit));

  // R9: wide accesses are never acknowledged
  a_r9_wide_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    io_wide |=> !io_ack);
endmodule

// File: tb/test_legacy_sysctl_ports.sv
module test_legacy_sysctl_ports;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic dev_rst = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_rd = 1'b0, io_wr = 1'b0, io_wide = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_ack, fpu_err = 1'b0, kbc_a20 = 1'b0;
  logic a20_gate, sys_reset_req, ferr_irq;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit cmp_en = 0;
  bit done = 0;
  string tag = "R4";

  // behavioural reference state
  int m_ctrl = 0, m_rdata = 0;
  bit m_ack = 0, m_pulse = 0, m_ferr = 0;

  always #5 clk = ~clk;

  legacy_sysctl_ports i_legacy_sysctl_ports (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wide(io_wide), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_ack(io_ack), .fpu_err(fpu_err), .kbc_a20(kbc_a20),
    .a20_gate(a20_gate), .sys_reset_req(sys_reset_req), .ferr_irq(ferr_irq)
  );

  // reference model: decides each response from the requirement text
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rdata = 0; m_ack = 0; m_pulse = 0; m_ferr = 0;
    end else begin
      int a;
      bit byte_acc, known;
      a = io_addr;
      byte_acc = !io_wide;
      known = (a == 'h92) || (a == 'h80) || (a == 'hF0);
      m_ack = byte_acc && known && (io_rd || io_wr);
      if (io_rd && byte_acc && a == 'h92) m_rdata = m_ctrl;
      else if (io_rd && byte_acc && (a == 'h80 || a == 'hF0)) m_rdata = 255;
      else m_rdata = 0;
      m_pulse = !dev_rst && io_wr && byte_acc && a == 'h92 && io_wdata[0];
      if (fpu_err) m_ferr = 1;
      else if (io_wr && byte_acc && a == 'hF0) m_ferr = 0;
      if (dev_rst) m_ctrl = m_ctrl & 'hFE;
      else if (io_wr && byte_acc && a == 'h92) m_ctrl = io_wdata;
    end
  end

  task automatic cmp(string req, string nm, int got, int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s (%s) %s: got %0h expected %0h", tag, req, nm, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      cmp("R10", "io_rdata", int'(io_rdata), m_rdata);
      cmp("R10", "io_ack", int'(io_ack), int'(m_ack));
      cmp("R2", "a20_gate", int'(a20_gate), int'(m_ctrl[1] | kbc_a20));
      cmp("R3", "sys_reset_req", int'(sys_reset_req), int'(m_pulse));
      cmp("R6", "ferr_irq", int'(ferr_irq), int'(m_ferr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
    io_rd = 0; io_wr = 0; io_wide = 0; fpu_err = 0; dev_rst = 0;
  endtask

  task automatic wr(input int a, input int d, input bit wide = 0);
    @(posedge clk); #2;
    io_addr = a[15:0]; io_wdata = d[7:0]; io_wr = 1; io_wide = wide;
    step();
  endtask

  task automatic rd(input int a, input bit wide = 0);
    @(posedge clk); #2;
    io_addr = a[15:0]; io_rd = 1; io_wide = wide;
    step();
  endtask

  initial begin
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1; cmp_en = 1;
    tag = "R4"; step(); step(); rd('h92);          // power-on state reads 0x00
    tag = "R1"; wr('h92, 'hA4); rd('h92); wr('h92, 'h5A); step(); rd('h92);
    tag = "R3"; wr('h92, 'h01); step(); wr('h92, 'h03); wr('h92, 'h81); rd('h92);
    tag = "R2"; wr('h92, 'h00); kbc_a20 = 1; step(); step(); kbc_a20 = 0;
    wr('h92, 'h02); kbc_a20 = 1; step(); kbc_a20 = 0; step();
    tag = "R4"; wr('h92, 'hFF);
    @(posedge clk); #2 dev_rst = 1; step(); rd('h92);
    @(posedge clk); #2 dev_rst = 1; io_addr = 'h92; io_wdata = 'h11; io_wr = 1; step(); rd('h92);
    tag = "R5"; wr('h80, 'h00); wr('h80, 'h3C); rd('h80); rd('h92);
    tag = "R6"; rd('hF0);
    @(posedge clk); #2 fpu_err = 1; step(); step(); step(); rd('hF0);
    wr('hF0, 'h00); step(); wr('hF0, 'h55);
    @(posedge clk); #2 fpu_err = 1; step(); wr('hF0, 'hFF); step();
    tag = "R7";
    @(posedge clk); #2 fpu_err = 1; io_addr = 'hF0; io_wr = 1; step(); step(); step();
    wr('hF0, 'h00); step();
    tag = "R8"; wr('h92, 'h40); wr('h93, 'hFF); rd('h93); rd('h1092); wr('h1092, 'h03);
    wr('h10F0, 'h00); rd('h0000); rd('h92);
    tag = "R9"; wr('h92, 'h07, 1); rd('h92, 1); rd('h80, 1); rd('h92);
    @(posedge clk); #2 fpu_err = 1; step(); wr('hF0, 'h00, 1); step(); rd('hF0);
    tag = "R10"; rd('h92); rd('h80); wr('h92, 'h00); step(); step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule